// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital sequencer placed in front of a successive-approximation converter core. Software writes a control register to choose a channel, a mode and whether the external trigger pin may start work. The block then runs one or more conversions. It hands each channel to the core through a one-cycle start strobe and waits for the core's done pulse. It files every result in a per-channel result register that carries a valid flag.

Two mode bits choose the operation. The block can convert one fixed channel or scan the channels from 0 up to the selected one. It can stop after one pass or repeat without end. A busy flag covers the whole run. An end-of-conversion flag and a one-cycle interrupt mark the end of every pass. A software start always aborts the current run and begins a new one. A falling edge on the trigger pin only has an effect while the block is idle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing address 0 with bit 0 set starts a run. `busy_o` is high from the next cycle, and the first `conv_start_o` strobe appears in that same cycle.
- R2: If control bit 5 (trigger enable) is 1, a falling edge on `trig_ni` starts a run. The pin passes through two synchronizer flops, so `busy_o` rises after the third rising clock edge following the fall. With bit 5 at 0, the pin has no effect.
- R3: A falling edge on `trig_ni` while `busy_o` is high starts nothing. No extra strobe and no extra interrupt follow from it.
- R4: A software start during a run abandons that run. No interrupt is raised for it. The new run's first strobe carries the first channel of the new mode, and that channel is 0 in scan modes.
- R5: The mode is {bit 2 repeat, bit 1 scan}. The selected channel is bits 4:3. Fixed modes convert only the selected channel. Scan modes convert channels 0 up to the selected channel, in ascending order.
- R6: In the single modes (repeat = 0), the pass ends when the last result is stored. After that edge, `busy_o` is low and the end-of-conversion flag is set. `irq_o` is high for exactly one cycle, the cycle after the storing edge.
- R7: In the continuous modes, the pass restarts at once and `busy_o` stays high. The end flag and `irq_o` fire after every pass. Writing address 0 with bit 2 = 0 and bit 0 = 0 during a run makes the current pass the last one.
- R8: Result register for channel c is read at address 4 + c. Bits 9:0 hold the data and bit 15 is the valid flag. Storing a result sets its valid flag.
- R9: A read of a result register clears its valid flag from the next cycle on. A store to the same channel on the same edge wins.
- R10: Reading address 0 returns scan, repeat, channel and trigger-enable in bits 1 to 5, busy in bit 6 and the end flag in bit 7; bit 0 reads 0. The read clears the end flag unless a pass ends on the same edge. The reset value reads 0.
- R11: `conv_start_o` is a one-cycle pulse, with the channel on `conv_ch_o`. `conv_done_i` is used only while a strobed conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (drives read side effects) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 6 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| trig_ni | input | 1 | External start trigger, active on falling edge |
| conv_start_o | output | 1 | Start strobe to converter core |
| conv_ch_o | output | 2 | Channel for the strobed conversion |
| conv_done_i | input | 1 | Core done pulse |
| conv_data_i | input | 10 | Core result, valid with done |
| busy_o | output | 1 | Run in progress |
| irq_o | output | 1 | One-cycle end-of-pass interrupt |

## Verification
A fault in the sequencer's channel counter or its latched mode shows on `conv_ch_o` at the very next strobe, which is one cycle after the previous result is stored. A busy or repeat fault shows on `busy_o` or `irq_o` in the cycle after the pass should have ended. Result and flag errors only surface when the registers are read. For that reason the bench compares the port outputs, including `reg_rdata_o`, against a behavioural model on every clock, and reads each register both right after a store and again right after a clearing read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned BIT_START  = 0;
  localparam int unsigned BIT_SCAN   = 1;
  localparam int unsigned BIT_REP    = 2;
  localparam int unsigned BIT_CHLO   = 3;
  localparam int unsigned BIT_TRIGEN = 5;
  localparam int unsigned BIT_BUSY   = 6;
  localparam int unsigned BIT_EOC    = 7;

  typedef enum logic [1:0] {
    MODE_FIX_ONE  = 2'b00,
    MODE_SCAN_ONE = 2'b01,
    MODE_FIX_RUN  = 2'b10,
    MODE_SCAN_RUN = 2'b11
  } mode_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '1;
    else         sh <= {sh[STAGES-1:0], pin_ni};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sw_start_i,
  input  logic            hw_start_i,
  input  mode_e           mode_i,
  input  logic [CH_W-1:0] ch_sel_i,
  input  logic            cfg_wr_i,
  input  logic            rep_wr_i,
  input  logic            conv_done_i,
  output logic            busy_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            store_o,
  output logic            seq_end_o
);
  logic            busy_q, issue_q, scan_q, rep_q;
  logic [CH_W-1:0] ch_q, last_q;
  logic            start, waiting, at_last, rep_eff;

  assign start     = sw_start_i | (hw_start_i & ~busy_q);
  assign waiting   = busy_q & ~issue_q;
  assign store_o   = waiting & conv_done_i & ~sw_start_i;
  assign at_last   = (ch_q == last_q);
  assign seq_end_o = store_o & at_last;
  // a config write with repeat cleared ends continuous operation after this pass
  assign rep_eff   = rep_q & ~(cfg_wr_i & ~rep_wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      issue_q <= 1'b0;
      scan_q  <= 1'b0;
      rep_q   <= 1'b0;
      ch_q    <= '0;
      last_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      issue_q <= 1'b1;
      scan_q  <= mode_i[0];
      rep_q   <= mode_i[1];
      last_q  <= ch_sel_i;
      ch_q    <= mode_i[0] ? '0 : ch_sel_i;
    end else begin
      rep_q   <= rep_eff;
      issue_q <= 1'b0;
      if (store_o) begin
        if (!at_last) begin
          ch_q    <= ch_q + 1'b1;
          issue_q <= 1'b1;
        end else if (rep_eff) begin
          ch_q    <= scan_q ? '0 : last_q;
          issue_q <= 1'b1;
        end else begin
          busy_q  <= 1'b0;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign conv_start_o = issue_q;
  assign conv_ch_o    = ch_q;

  a_r1_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (busy_q && issue_q));
  a_r3_trig_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && hw_start_i && !sw_start_i && !store_o) |=> !issue_q);
  a_r11_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_q && !sw_start_i) |=> !issue_q);
  a_r6_single_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_end_o && !rep_eff && !sw_start_i) |=> !busy_q);
  a_r7_run_stays_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_end_o && rep_eff) |=> (busy_q && issue_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [CH_W-1:0]                wr_ch_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           rd_clr_i,
  input  logic [CH_W-1:0]                rd_ch_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  data_o,
  output logic [NUM_CH-1:0]              valid_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit_wr, hit_rd;
    assign hit_wr = wr_i & (wr_ch_i == CH_W'(g));
    assign hit_rd = rd_clr_i & (rd_ch_i == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g]  <= '0;
        valid_o[g] <= 1'b0;
      end else if (hit_wr) begin
        data_o[g]  <= wr_data_i;
        valid_o[g] <= 1'b1;
      end else if (hit_rd) begin
        valid_o[g] <= 1'b0;
      end
    end
  end

  a_r8_store_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o[$past(wr_ch_i)]);
  a_r9_read_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !(wr_i && wr_ch_i == rd_ch_i)) |=> !valid_o[$past(rd_ch_i)]);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned WDATA_W = 6,
  parameter int unsigned RDATA_W = 16,
  parameter int unsigned SYNC_N  = 2,
  localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WDATA_W-1:0] reg_wdata_i,
  output logic [RDATA_W-1:0] reg_rdata_o,
  input  logic               trig_ni,
  output logic               conv_start_o,
  output logic [CH_W-1:0]    conv_ch_o,
  input  logic               conv_done_i,
  input  logic [DATA_W-1:0]  conv_data_i,
  output logic               busy_o,
  output logic               irq_o
);
  logic            cfg_scan, cfg_rep, cfg_ten, eoc_q, irq_q;
  logic [CH_W-1:0] cfg_ch;
  logic            nx_scan, nx_rep, nx_ten;
  logic [CH_W-1:0] nx_ch;
  logic            wr_cfg, rd_cfg, rd_res, sw_start, trig_fall;
  logic            store, seq_end;
  logic [CH_W-1:0] rd_ch;
  logic [NUM_CH-1:0][DATA_W-1:0] res_data;
  logic [NUM_CH-1:0]             res_valid;

  assign wr_cfg   = reg_we_i & (reg_addr_i == '0);
  assign rd_cfg   = reg_re_i & (reg_addr_i == '0);
  assign rd_res   = reg_re_i & reg_addr_i[ADDR_W-1];
  assign rd_ch    = reg_addr_i[CH_W-1:0];
  assign sw_start = wr_cfg & reg_wdata_i[BIT_START];

  assign nx_scan = wr_cfg ? reg_wdata_i[BIT_SCAN]          : cfg_scan;
  assign nx_rep  = wr_cfg ? reg_wdata_i[BIT_REP]           : cfg_rep;
  assign nx_ch   = wr_cfg ? reg_wdata_i[BIT_CHLO +: CH_W]  : cfg_ch;
  assign nx_ten  = wr_cfg ? reg_wdata_i[BIT_TRIGEN]        : cfg_ten;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_scan <= 1'b0;
      cfg_rep  <= 1'b0;
      cfg_ch   <= '0;
      cfg_ten  <= 1'b0;
      eoc_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cfg_scan <= nx_scan;
      cfg_rep  <= nx_rep;
      cfg_ch   <= nx_ch;
      cfg_ten  <= nx_ten;
      irq_q    <= seq_end;
      if (seq_end)     eoc_q <= 1'b1;
      else if (rd_cfg) eoc_q <= 1'b0;
    end
  end

  adc_trig_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (trig_ni),
    .fall_o (trig_fall)
  );

  adc_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_start_i   (sw_start),
    .hw_start_i   (trig_fall & cfg_ten),
    .mode_i       (mode_e'({nx_rep, nx_scan})),
    .ch_sel_i     (nx_ch),
    .cfg_wr_i     (wr_cfg),
    .rep_wr_i     (reg_wdata_i[BIT_REP]),
    .conv_done_i  (conv_done_i),
    .busy_o       (busy_o),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .store_o      (store),
    .seq_end_o    (seq_end)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (store),
    .wr_ch_i   (conv_ch_o),
    .wr_data_i (conv_data_i),
    .rd_clr_i  (rd_res),
    .rd_ch_i   (rd_ch),
    .data_o    (res_data),
    .valid_o   (res_valid)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[ADDR_W-1]) begin
      reg_rdata_o[DATA_W-1:0] = res_data[rd_ch];
      reg_rdata_o[RDATA_W-1]  = res_valid[rd_ch];
    end else if (reg_addr_i == '0) begin
      reg_rdata_o[BIT_SCAN]           = cfg_scan;
      reg_rdata_o[BIT_REP]            = cfg_rep;
      reg_rdata_o[BIT_CHLO +: CH_W]   = cfg_ch;
      reg_rdata_o[BIT_TRIGEN]         = cfg_ten;
      reg_rdata_o[BIT_BUSY]           = busy_o;
      reg_rdata_o[BIT_EOC]            = eoc_q;
    end
  end

  assign irq_o = irq_q;

  a_r6_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_end_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end |=> (eoc_q && irq_o));
  a_r10_eoc_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cfg && !seq_end) |=> !eoc_q);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int CLK_T = 10;
  localparam int LAT   = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0, trig_n = 1'b1, cdone = 1'b0;
  logic [2:0] addr = '0;
  logic [5:0] wd = '0;
  logic [9:0] cdata = '0;
  logic [15:0] rdata;
  logic       cstart, busy, irq;
  logic [1:0] cch;

  int checks = 0, fails = 0, cycles = 0;
  int strobes = 0, irqs = 0, cnt = 0, seqn = 0;
  logic [1:0] core_ch;
  int ch_log[$];
  logic [9:0] last_data [4];

  // reference model state
  logic m_busy, m_issue, m_scan, m_rep, m_eoc, m_irq;
  logic [1:0] m_ch, m_last;
  logic c_scan, c_rep, c_ten;
  logic [1:0] c_ch;
  logic [9:0] m_res [4];
  logic m_val [4];
  logic s1, s2, s3;
  logic t_wr0, t_sw, t_hw, t_wait, t_st, t_stor, t_end, t_repeff;
  logic t_nscan, t_nrep, t_nten;
  logic [1:0] t_nch;

  always #(CLK_T/2) clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .trig_ni(trig_n), .conv_start_o(cstart), .conv_ch_o(cch),
    .conv_done_i(cdone), .conv_data_i(cdata), .busy_o(busy), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // converter core stand-in and port monitors
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      cdone = 1'b0; cnt = 0;
    end else begin
      cdone = 1'b0;
      if (cnt != 0) begin
        cnt--;
        if (cnt == 0) begin
          cdone = 1'b1;
          cdata = 10'((seqn * 37 + int'(core_ch) * 5 + 3) % 1024);
          last_data[core_ch] = cdata;
        end
      end
      if (cstart) begin
        cdone = 1'b0; cnt = LAT; core_ch = cch; seqn++; strobes++;
        ch_log.push_back(int'(cch));
      end
      if (irq) irqs++;
    end
  end

  // behavioural reference, advanced on the same inputs as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_issue = 0; m_scan = 0; m_rep = 0; m_eoc = 0; m_irq = 0;
      m_ch = 0; m_last = 0; c_scan = 0; c_rep = 0; c_ten = 0; c_ch = 0;
      s1 = 1; s2 = 1; s3 = 1;
      for (int i = 0; i < 4; i++) begin m_res[i] = 0; m_val[i] = 0; end
    end else begin
      t_wr0   = we && addr == 3'd0;
      t_sw    = t_wr0 && wd[0];
      t_nscan = t_wr0 ? wd[1] : c_scan;
      t_nrep  = t_wr0 ? wd[2] : c_rep;
      t_nch   = t_wr0 ? wd[4:3] : c_ch;
      t_nten  = t_wr0 ? wd[5] : c_ten;
      t_hw    = s3 && !s2 && c_ten;
      t_wait  = m_busy && !m_issue;
      t_st    = t_sw || (t_hw && !m_busy);
      t_stor  = t_wait && cdone && !t_sw;
      t_end   = t_stor && (m_ch == m_last);
      t_repeff = m_rep && !(t_wr0 && !wd[2]);
      for (int i = 0; i < 4; i++) begin
        if (t_stor && int'(m_ch) == i) begin m_res[i] = cdata; m_val[i] = 1; end
        else if (re && addr[2] && int'(addr[1:0]) == i) m_val[i] = 0;
      end
      if (t_end) m_eoc = 1; else if (re && addr == 3'd0) m_eoc = 0;
      m_irq = t_end;
      if (t_st) begin
        m_busy = 1; m_issue = 1; m_scan = t_nscan; m_rep = t_nrep; m_last = t_nch;
        m_ch = t_nscan ? 2'd0 : t_nch;
      end else begin
        m_rep = t_repeff; m_issue = 0;
        if (t_stor) begin
          if (m_ch != m_last) begin m_ch = m_ch + 1; m_issue = 1; end
          else if (t_repeff) begin m_ch = m_scan ? 2'd0 : m_last; m_issue = 1; end
          else m_busy = 0;
        end
      end
      c_scan = t_nscan; c_rep = t_nrep; c_ch = t_nch; c_ten = t_nten;
      s3 = s2; s2 = s1; s1 = trig_n;
    end
  end

  function automatic logic [15:0] exp_rdata();
    logic [15:0] v = '0;
    if (addr[2]) begin v[9:0] = m_res[addr[1:0]]; v[15] = m_val[addr[1:0]]; end
    else if (addr == 3'd0) v = {8'd0, m_eoc, m_busy, c_ten, c_ch, c_rep, c_scan, 1'b0};
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R1 busy", busy, m_busy);
      chk(cstart == m_issue, "R11 strobe", cstart, m_issue);
      if (m_issue) chk(cch == m_ch, "R5 channel", cch, m_ch);
      chk(irq == m_irq, "R6 irq", irq, m_irq);
      chk(rdata == exp_rdata(), "R8 rdata", rdata, exp_rdata());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [5:0] d);
    @(posedge clk); #1; we = 1; addr = a; wd = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] v);
    @(posedge clk); #1; re = 1; addr = a;
    @(negedge clk); v = rdata;
    @(posedge clk); #1; re = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_trig(input int low_cycles);
    @(posedge clk); #1; trig_n = 0;
    repeat (low_cycles) @(posedge clk);
    #1; trig_n = 1;
  endtask

  initial begin
    logic [15:0] v;
    int s0, i0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    reg_read(3'd0, v);
    chk(v == 16'd0, "R10 reset value", v, 0);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);

    // fixed single on channel 2
    s0 = strobes; i0 = irqs;
    reg_write(3'd0, 6'h11);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    wait_idle();
    chk(strobes - s0 == 1, "R6 one conversion", strobes - s0, 1);
    chk(ch_log[$] == 2, "R5 fixed channel", ch_log[$], 2);
    chk(irqs - i0 == 1, "R6 one irq", irqs - i0, 1);
    reg_read(3'd6, v);
    chk(v[15] == 1'b1, "R8 valid set", v[15], 1);
    chk(v[9:0] == last_data[2], "R8 data", v[9:0], last_data[2]);
    reg_read(3'd6, v);
    chk(v[15] == 1'b0, "R9 valid cleared by read", v[15], 0);
    reg_read(3'd0, v);
    chk(v[7] == 1'b1, "R10 eoc set", v[7], 1);
    reg_read(3'd0, v);
    chk(v[7] == 1'b0, "R10 eoc cleared by read", v[7], 0);

    // scan single, channels 0..3
    ch_log.delete(); i0 = irqs;
    reg_write(3'd0, 6'h1B);
    wait_idle();
    chk(ch_log.size() == 4, "R5 scan count", ch_log.size(), 4);
    for (int k = 0; k < 4 && k < ch_log.size(); k++)
      chk(ch_log[k] == k, "R5 scan order", ch_log[k], k);
    chk(irqs - i0 == 1, "R6 irq after whole pass", irqs - i0, 1);
    reg_read(3'd4, v);
    chk(v[15] == 1'b1, "R8 channel 0 valid", v[15], 1);

    // external trigger, scan to channel 1
    reg_write(3'd0, 6'h2A);
    chk(busy == 1'b0, "R2 config write alone starts nothing", busy, 0);
    s0 = strobes; i0 = irqs;
    @(posedge clk); #1; trig_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after sync delay", busy, 1);
    @(posedge clk); #1; trig_n = 1;
    pulse_trig(3);
    chk(busy == 1'b1, "R3 still in first run", busy, 1);
    wait_idle();
    chk(strobes - s0 == 2, "R3 trigger while busy ignored", strobes - s0, 2);
    chk(irqs - i0 == 1, "R3 single irq", irqs - i0, 1);

    // trigger disabled
    reg_write(3'd0, 6'h0A);
    s0 = strobes;
    pulse_trig(4);
    repeat (6) @(negedge clk);
    chk(strobes - s0 == 0, "R2 trigger disabled", strobes - s0, 0);
    chk(busy == 1'b0, "R2 no busy when disabled", busy, 0);

    // abort with software start
    s0 = strobes; i0 = irqs;
    reg_write(3'd0, 6'h1B);
    while (strobes - s0 < 2) @(negedge clk);
    ch_log.delete();
    reg_write(3'd0, 6'h1B);
    wait_idle();
    chk(ch_log.size() == 4, "R4 restarted pass length", ch_log.size(), 4);
    if (ch_log.size() > 0) chk(ch_log[0] == 0, "R4 restart at channel 0", ch_log[0], 0);
    chk(irqs - i0 == 1, "R4 aborted pass raises no irq", irqs - i0, 1);

    // continuous fixed on channel 1, then stop
    s0 = strobes; i0 = irqs;
    reg_write(3'd0, 6'h0D);
    while (irqs - i0 < 3) @(negedge clk);
    chk(busy == 1'b1, "R7 busy stays in continuous", busy, 1);
    reg_write(3'd0, 6'h08);
    wait_idle();
    chk(busy == 1'b0, "R7 stop after repeat cleared", busy, 0);
    chk(strobes - s0 == irqs - i0, "R7 irq every pass", irqs - i0, strobes - s0);

    // continuous scan to channel 3, then stop
    ch_log.delete(); i0 = irqs;
    reg_write(3'd0, 6'h1F);
    while (irqs - i0 < 2) @(negedge clk);
    reg_write(3'd0, 6'h18);
    wait_idle();
    for (int k = 0; k < 8 && k < ch_log.size(); k++)
      chk(ch_log[k] == k % 4, "R5 continuous scan order", ch_log[k], k % 4);
    chk(ch_log.size() % 4 == 0, "R7 passes complete", ch_log.size() % 4, 0);

    repeat (4) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule